// File: doc/BRIEF.md
# Inter-Processor Interrupt Destination Selector

This block takes an inter-processor interrupt request, given as a low and a high command word, and works out which of N local interrupt units it reaches. It decodes the shorthand code, the destination mode, the delivery mode and the vector from the command. It then compares the destination byte with each unit's physical ID and its logical ID, and applies the destination format that unit has chosen. The result is a per-unit delivery mask, registered one cycle after the command is presented.

In lowest-priority delivery the block does not send to every matching unit. It keeps a round-robin pointer and picks a single unit that matches, is present and is enabled. The block also keeps a cleaned copy of the last command words, in the form a register read would return them. Acceptance of the interrupt by the chosen units is left to the logic downstream.

Top module: `ipi_dest_select`

## Requirements
- R1: With shorthand code 1 (low word bits [19:18]), the mask holds only the bit of the sender index, and only if that unit is present.
- R2: With shorthand code 2, the mask holds every present unit, the sender included.
- R3: With shorthand code 3, the mask holds every present unit except the sender.
- R4: With shorthand code 0 and low word bit 11 at 0 (physical mode), a present unit matches when the destination byte (high word bits [31:24]) is 0xFF or equals its ID. Outside lowest-priority delivery the enable inputs have no effect.
- R5: With shorthand code 0 and bit 11 at 1 (logical mode), a unit whose format is flat matches when its logical ID ANDed with the destination byte is nonzero.
- R6: A unit whose format is cluster matches in logical mode when the upper nibbles of its logical ID and of the destination are equal and the lower nibbles have at least one set bit in common.
- R7: Only bits [31:28] of a unit's format word count, because bits [27:0] are taken as ones. A value of 0xF selects flat, 0x0 selects cluster, and any other value matches nothing.
- R8: With delivery mode 3'b001 (low word bits [10:8]), exactly one unit is chosen. The scan starts at the unit after the previous choice, wraps at N, takes the first unit that matches, is present and is enabled, and records it as the new previous choice. After reset the previous choice is unit 0.
- R9: In lowest-priority delivery with no eligible unit, the mask is zero and the round-robin pointer is unchanged.
- R10: The held low word equals the last accepted low word with bit 12 cleared. The held high word keeps only bits [31:24] of the last accepted high word.
- R11: The valid output goes high for exactly one cycle, on the clock edge after a cycle with cmd_valid high. In that cycle the vector (low word bits [7:0]) and the delivery mode appear alongside the mask.
- R12: During reset, the valid output, the mask and both held words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command words are presented this cycle |
| cmd_lo | input | 32 | Low command word: vector, delivery mode, destination mode, shorthand |
| cmd_hi | input | 32 | High command word; destination byte in [31:24] |
| sender | input | $clog2(N) | Index of the sending unit |
| unit_id | input | 8*N | Physical ID of each unit, unit i at [8i+7:8i] |
| unit_lid | input | 8*N | Logical ID of each unit |
| unit_fmt | input | 32*N | Raw destination-format word of each unit |
| unit_present | input | N | Unit exists |
| unit_enable | input | N | Unit is enabled (used by lowest-priority choice) |
| dlv_valid | output | 1 | Delivery result valid |
| dlv_mask | output | N | Units that receive the interrupt |
| dlv_vector | output | 8 | Vector of the command |
| dlv_mode | output | 3 | Delivery mode of the command |
| held_lo | output | 32 | Cleaned copy of the last low word |
| held_hi | output | 32 | Cleaned copy of the last high word |

## Verification
The round-robin wrap is driven through an absent top unit and a sparse enable pattern. A selector that restarts at unit 0, or that fails to skip the absent unit, would pick a different target. An empty lowest-priority round is followed by a non-empty one, so a pointer that moved on the empty round shows up as a wrong pick. Format words with their low bits cleared, and one with an unknown top nibble, catch a decoder that reads the wrong bits or treats unknown formats as flat. Broadcast, exclusion of the sender and the cleared delivery-status bit are each checked against fixed expected masks and words.

// File: rtl/ipi_dest_select.sv
module ipi_dest_select #(
  parameter int N = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [31:0]                cmd_lo,
  input  logic [31:0]                cmd_hi,
  input  logic [$clog2(N)-1:0]       sender,
  input  logic [8*N-1:0]             unit_id,
  input  logic [8*N-1:0]             unit_lid,
  input  logic [32*N-1:0]            unit_fmt,
  input  logic [N-1:0]               unit_present,
  input  logic [N-1:0]               unit_enable,
  output logic                       dlv_valid,
  output logic [N-1:0]               dlv_mask,
  output logic [7:0]                 dlv_vector,
  output logic [2:0]                 dlv_mode,
  output logic [31:0]                held_lo,
  output logic [31:0]                held_hi
);
  localparam int IW = $clog2(N);
  localparam logic [2:0] MODE_LOWEST = 3'b001;

  logic [1:0] shorthand;
  logic       logical;
  logic [2:0] mode;
  logic [7:0] dest;
  logic       lowest;
  logic [N-1:0] hit, cand, pick;
  logic [IW-1:0] pick_idx, rr_last;
  logic found;

  assign shorthand = cmd_lo[19:18];
  assign logical   = cmd_lo[11];
  assign mode      = cmd_lo[10:8];
  assign dest      = cmd_hi[31:24];
  assign lowest    = (mode == MODE_LOWEST);

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_unit
      logic [7:0] uid, lid;
      logic [3:0] fmt_top;
      logic phys_hit, flat_hit, clus_hit, log_hit, sel;
      assign uid      = unit_id[gi*8 +: 8];
      assign lid      = unit_lid[gi*8 +: 8];
      assign fmt_top  = unit_fmt[gi*32+28 +: 4];
      assign phys_hit = (dest == 8'hFF) || (dest == uid);
      assign flat_hit = |(lid & dest);
      assign clus_hit = (lid[7:4] == dest[7:4]) && |(lid[3:0] & dest[3:0]);
      assign log_hit  = (fmt_top == 4'hF) ? flat_hit :
                        (fmt_top == 4'h0) ? clus_hit : 1'b0;
      always_comb begin
        case (shorthand)
          2'd0:    sel = logical ? log_hit : phys_hit;
          2'd1:    sel = (sender == IW'(gi));
          2'd2:    sel = 1'b1;
          default: sel = (sender != IW'(gi));
        endcase
      end
      assign hit[gi] = sel & unit_present[gi];
    end
  endgenerate

  assign cand = hit & unit_enable;

  always_comb begin
    int j;
    pick     = '0;
    pick_idx = rr_last;
    found    = 1'b0;
    for (int k = 1; k <= N; k++) begin
      j = int'(rr_last) + k;
      if (j >= N) j = j - N;
      if (!found && cand[j]) begin
        found    = 1'b1;
        pick[j]  = 1'b1;
        pick_idx = IW'(j);
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{cmd_hi[23:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dlv_valid  <= 1'b0;
      dlv_mask   <= '0;
      dlv_vector <= '0;
      dlv_mode   <= '0;
      held_lo    <= '0;
      held_hi    <= '0;
      rr_last    <= '0;
    end else begin
      dlv_valid <= cmd_valid;
      if (cmd_valid) begin
        dlv_mask   <= lowest ? pick : hit;
        dlv_vector <= cmd_lo[7:0];
        dlv_mode   <= mode;
        held_lo    <= cmd_lo & ~(32'h1 << 12);
        held_hi    <= {cmd_hi[31:24], 24'h0};
        if (lowest && found) rr_last <= pick_idx;
      end
    end
  end

  // R8
  lowest_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && dlv_mode == MODE_LOWEST |-> $onehot0(dlv_mask));

  // R1
  self_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_lo[19:18] == 2'd1 |=> $onehot0(dlv_mask));

  // R3
  excl_sender_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_lo[19:18] == 2'd3 |=> !dlv_mask[$past(sender)]);

  // R9
  rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_lo[10:8] == MODE_LOWEST) |=> $stable(rr_last));

  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !dlv_valid);

  // R4
  present_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (dlv_mask & ~$past(unit_present)) == '0);
endmodule

// File: tb/test_ipi_dest_select.sv
module test_ipi_dest_select;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [31:0] cmd_lo = '0, cmd_hi = '0;
  logic [2:0] sender = '0;
  logic [8*N-1:0] unit_id, unit_lid;
  logic [32*N-1:0] unit_fmt;
  logic [N-1:0] unit_present, unit_enable;
  logic dlv_valid;
  logic [N-1:0] dlv_mask;
  logic [7:0] dlv_vector;
  logic [2:0] dlv_mode;
  logic [31:0] held_lo, held_hi;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ipi_dest_select #(.N(N)) i_ipi_dest_select (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_lo(cmd_lo),
    .cmd_hi(cmd_hi), .sender(sender), .unit_id(unit_id), .unit_lid(unit_lid),
    .unit_fmt(unit_fmt), .unit_present(unit_present), .unit_enable(unit_enable),
    .dlv_valid(dlv_valid), .dlv_mask(dlv_mask), .dlv_vector(dlv_vector),
    .dlv_mode(dlv_mode), .held_lo(held_lo), .held_hi(held_hi));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_lo(logic [1:0] sh, logic dm, logic [2:0] md, logic [7:0] vec);
    return {12'h0, sh, 6'h0, dm, md, vec};
  endfunction

  task automatic fire(logic [31:0] lo, logic [7:0] dst, logic [2:0] snd);
    @(negedge clk);
    cmd_lo = lo; cmd_hi = {dst, 24'h0}; sender = snd; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic set_fmt(logic [31:0] w);
    for (int i = 0; i < N; i++) unit_fmt[i*32 +: 32] = w;
  endtask

  task automatic t_reset;
    chk("R12 valid", {31'h0, dlv_valid}, 0);
    chk("R12 mask", {24'h0, dlv_mask}, 0);
    chk("R12 held_lo", held_lo, 0);
    chk("R12 held_hi", held_hi, 0);
  endtask

  task automatic t_shorthand;
    fire(mk_lo(2'd1, 0, 3'd0, 8'h40), 8'h00, 3'd3);
    chk("R1 self", {24'h0, dlv_mask}, 32'h08);
    fire(mk_lo(2'd2, 0, 3'd0, 8'h40), 8'h00, 3'd2);
    chk("R2 all incl", {24'h0, dlv_mask}, 32'h7F);
    fire(mk_lo(2'd3, 0, 3'd0, 8'h40), 8'h00, 3'd2);
    chk("R3 all excl", {24'h0, dlv_mask}, 32'h7B);
  endtask

  task automatic t_physical;
    fire(mk_lo(2'd0, 0, 3'd0, 8'h41), 8'h13, 3'd0);
    chk("R4 id match", {24'h0, dlv_mask}, 32'h08);
    fire(mk_lo(2'd0, 0, 3'd0, 8'h41), 8'hFF, 3'd0);
    chk("R4 broadcast", {24'h0, dlv_mask}, 32'h7F);
    fire(mk_lo(2'd0, 0, 3'd0, 8'h41), 8'h55, 3'd0);
    chk("R4 no match", {24'h0, dlv_mask}, 32'h00);
    unit_enable = '0;
    fire(mk_lo(2'd0, 0, 3'd0, 8'h41), 8'h13, 3'd0);
    chk("R4 enable ignored", {24'h0, dlv_mask}, 32'h08);
    unit_enable = '1;
  endtask

  task automatic t_logical;
    for (int i = 0; i < N; i++) unit_lid[i*8 +: 8] = 8'(1 << i);
    set_fmt(32'hFFFF_FFFF);
    fire(mk_lo(2'd0, 1, 3'd0, 8'h42), 8'h05, 3'd0);
    chk("R5 flat", {24'h0, dlv_mask}, 32'h05);
    unit_lid = {8'h28, 8'h24, 8'h22, 8'h21, 8'h18, 8'h14, 8'h12, 8'h11};
    set_fmt(32'h0000_0000);
    fire(mk_lo(2'd0, 1, 3'd0, 8'h42), 8'h13, 3'd0);
    chk("R6 cluster one", {24'h0, dlv_mask}, 32'h03);
    fire(mk_lo(2'd0, 1, 3'd0, 8'h42), 8'h2F, 3'd0);
    chk("R6 cluster two", {24'h0, dlv_mask}, 32'h70);
    set_fmt(32'hF000_0000);
    fire(mk_lo(2'd0, 1, 3'd0, 8'h42), 8'h10, 3'd0);
    chk("R7 top nibble flat", {24'h0, dlv_mask}, 32'h0F);
    set_fmt(32'h5FFF_FFFF);
    fire(mk_lo(2'd0, 1, 3'd0, 8'h42), 8'h10, 3'd0);
    chk("R7 unknown format", {24'h0, dlv_mask}, 32'h00);
  endtask

  task automatic t_lowest;
    logic [31:0] lo;
    lo = mk_lo(2'd2, 0, 3'b001, 8'h50);
    fire(lo, 8'h00, 3'd0);
    chk("R8 first pick", {24'h0, dlv_mask}, 32'h02);
    fire(lo, 8'h00, 3'd0);
    chk("R8 next pick", {24'h0, dlv_mask}, 32'h04);
    unit_enable = 8'h41;
    fire(lo, 8'h00, 3'd0);
    chk("R8 skip disabled", {24'h0, dlv_mask}, 32'h40);
    fire(lo, 8'h00, 3'd0);
    chk("R8 wrap past absent", {24'h0, dlv_mask}, 32'h01);
    fire(lo, 8'h00, 3'd0);
    chk("R8 scan from 1", {24'h0, dlv_mask}, 32'h40);
    unit_enable = 8'h00;
    fire(lo, 8'h00, 3'd0);
    chk("R9 none eligible", {24'h0, dlv_mask}, 32'h00);
    unit_enable = 8'h41;
    fire(lo, 8'h00, 3'd0);
    chk("R9 pointer kept", {24'h0, dlv_mask}, 32'h01);
    unit_enable = '1;
  endtask

  task automatic t_held;
    @(negedge clk);
    cmd_lo = 32'hFFFF_F15A; cmd_hi = 32'h1234_5678; sender = 3'd1; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 held_lo", held_lo, 32'hFFFF_E15A);
    chk("R10 held_hi", held_hi, 32'h1200_0000);
    chk("R11 valid", {31'h0, dlv_valid}, 1);
    chk("R11 vector", {24'h0, dlv_vector}, 32'h5A);
    chk("R11 mode", {29'h0, dlv_mode}, 32'h1);
    @(negedge clk);
    chk("R11 one cycle", {31'h0, dlv_valid}, 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) unit_id[i*8 +: 8] = 8'(8'h10 + i);
    unit_lid = '0;
    set_fmt(32'hFFFF_FFFF);
    unit_present = 8'h7F;
    unit_enable = '1;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_shorthand;
    t_physical;
    t_logical;
    t_lowest;
    t_held;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule